// File: doc/BRIEF.md
# Startup Eye-Centering Calibration Sequencer

This block sets the input delay of each serial lane once, at system start, while the far end sends a known training word. For the lane under calibration it first resets the lane's delay line to tap zero. It then raises the delay one tap at a time, and at every tap decides whether the deserialized parallel word is sampled cleanly. It keeps the longest unbroken run of clean taps, resets the delay again and climbs back up to the middle of that run. The delay then stays there for normal traffic. Because the whole tap range is searched, the result does not depend on the phase between the sampling clock and the data.

Lanes are handled strictly one after another. A second mode skips the search and puts a lane at a step count supplied on an input. When every lane has found a window, a completion flag rises. A lane with no clean tap is reported on its own failure bit, and the completion flag stays low.

Top module: `eye_cal_seq`

## Requirements
- R1: While rst_ni is low, and after it is released until start_i is seen, every bit of dly_rst_o, dly_ce_o, done_o and cal_fail_o is low.
- R2: A start_i pulse calibrates lane 0 first, then lanes 1, 2 and so on in rising order. Only the lane being calibrated receives delay pulses, and no lane receives pulses again once a higher lane has started.
- R3: A lane's delay changes only by a one-cycle reset pulse on dly_rst_o (delay becomes tap 0) or by a one-cycle pulse on dly_ce_o with dly_inc_o high (delay rises by one tap). The delay is never lowered by a step and never exceeds TAP_MAX.
- R4: At each tap the block waits SETTLE cycles and then compares MATCH_N consecutive words of the lane, taken from rx_words_i bits [lane*WORD_W +: WORD_W], with pattern_i. The tap counts as clean only when all MATCH_N words are equal to pattern_i.
- R5: The chosen window is the longest run of consecutive clean taps in 0..TAP_MAX. If several runs have the same length, the lowest-numbered run wins.
- R6: After the sweep the lane receives a reset pulse and then exactly floor((first+last)/2) increment pulses, where first and last are the end taps of the chosen window.
- R7: A lane with no clean tap is left at tap 0, and its bit in cal_fail_o is high once the sequence finishes. Calibration still continues with the following lanes.
- R8: After the last lane, done_o is high only if no lane failed. done_o and cal_fail_o then hold, with no further delay pulses, until the next start_i.
- R9: If mode_fixed_i is high when a lane starts, that lane gets a reset pulse and then exactly min(fixed_steps_i, TAP_MAX) increment pulses. No sweep is done and the lane never fails.
- R10: A start_i pulse given after a finished sequence clears the flags and runs the full calibration again from lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a calibration pass over all lanes |
| mode_fixed_i | input | 1 | 1: apply fixed_steps_i instead of sweeping |
| fixed_steps_i | input | TAP_W | Step count used in fixed mode |
| pattern_i | input | WORD_W | Expected training word |
| rx_words_i | input | NUM_LANES*WORD_W | Deserialized words, lane n at bits [n*WORD_W +: WORD_W] |
| dly_rst_o | output | NUM_LANES | Per-lane delay reset pulse (to tap 0) |
| dly_ce_o | output | NUM_LANES | Per-lane delay step enable |
| dly_inc_o | output | NUM_LANES | Per-lane step direction, high for up |
| done_o | output | 1 | All lanes calibrated successfully |
| cal_fail_o | output | NUM_LANES | Per-lane flag: no clean tap found |

## Verification
The lanes are given clean-tap maps of several shapes. A single window in the middle or at either end of the range checks the midpoint rounding. Two windows of different length show whether the longest run is really chosen, and two windows of equal length show whether the first one wins. A single clean tap, a fully clean range and an empty map check the limits and the failure path. Some taps fail only on one word out of four; they show whether every compared word must match, and they can split a window in two. Fixed-mode runs, restarts without reset, and seeded random maps check the final tap against a separate model of the delay line driven only by the output pulses.

// File: rtl/eye_cal_pkg.sv
package eye_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LANE_RST,
    ST_JUDGE,
    ST_SWEEP_STEP,
    ST_RECENTER,
    ST_SEEK,
    ST_NEXT,
    ST_DONE
  } cal_state_e;
endpackage

// File: rtl/eye_cal_tap_judge.sv
module eye_cal_tap_judge #(
  parameter int WORD_W  = 8,
  parameter int SETTLE  = 4,
  parameter int MATCH_N = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] pattern_i,
  output logic              done_o,
  output logic              pass_o
);
  localparam int CMAX  = (SETTLE > MATCH_N) ? SETTLE : MATCH_N;
  localparam int CNT_W = $clog2(CMAX + 1);

  logic             active_q, cmp_q, ok_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ok_n;

  assign ok_n = ok_q & (word_i == pattern_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cmp_q    <= 1'b0;
      ok_q     <= 1'b0;
      cnt_q    <= '0;
      done_o   <= 1'b0;
      pass_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        active_q <= 1'b1;
        cmp_q    <= 1'b0;
        ok_q     <= 1'b1;
        cnt_q    <= '0;
      end else if (active_q) begin
        if (!cmp_q) begin
          // settle: let the new tap reach the parallel word
          if (cnt_q == CNT_W'(SETTLE - 1)) begin
            cmp_q <= 1'b1;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          ok_q <= ok_n;
          if (cnt_q == CNT_W'(MATCH_N - 1)) begin
            active_q <= 1'b0;
            done_o   <= 1'b1;
            pass_o   <= ok_n;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/eye_cal_window.sv
module eye_cal_window #(
  parameter int TAP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic             pass_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             found_o,
  output logic [TAP_W-1:0] mid_o
);
  logic [TAP_W-1:0] run_lo_q, best_lo_q, best_hi_q, cur_lo;
  logic [TAP_W:0]   run_len_q, best_len_q, cur_len, sum;

  assign cur_lo  = (run_len_q == '0) ? tap_i : run_lo_q;
  assign cur_len = run_len_q + 1'b1;
  assign sum     = {1'b0, best_lo_q} + {1'b0, best_hi_q};
  assign mid_o   = sum[TAP_W:1];
  assign found_o = (best_len_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_lo_q   <= '0;
      run_len_q  <= '0;
      best_lo_q  <= '0;
      best_hi_q  <= '0;
      best_len_q <= '0;
    end else if (clr_i) begin
      run_lo_q   <= '0;
      run_len_q  <= '0;
      best_lo_q  <= '0;
      best_hi_q  <= '0;
      best_len_q <= '0;
    end else if (upd_i) begin
      if (pass_i) begin
        run_lo_q  <= cur_lo;
        run_len_q <= cur_len;
        // strict compare: earlier run kept on a tie
        if (cur_len > best_len_q) begin
          best_len_q <= cur_len;
          best_lo_q  <= cur_lo;
          best_hi_q  <= tap_i;
        end
      end else begin
        run_len_q <= '0;
      end
    end
  end
endmodule

// File: rtl/eye_cal_dly_drive.sv
module eye_cal_dly_drive #(
  parameter int NUM_LANES = 2,
  parameter int LANE_W    = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [LANE_W-1:0]    lane_i,
  input  logic                 rst_req_i,
  input  logic                 step_req_i,
  output logic [NUM_LANES-1:0] dly_rst_o,
  output logic [NUM_LANES-1:0] dly_ce_o,
  output logic [NUM_LANES-1:0] dly_inc_o
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic sel;
    assign sel = (lane_i == LANE_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dly_rst_o[g] <= 1'b0;
        dly_ce_o[g]  <= 1'b0;
        dly_inc_o[g] <= 1'b0;
      end else begin
        dly_rst_o[g] <= sel & rst_req_i;
        dly_ce_o[g]  <= sel & step_req_i;
        dly_inc_o[g] <= sel & step_req_i;
      end
    end
  end
endmodule

// File: rtl/eye_cal_seq.sv
module eye_cal_seq
  import eye_cal_pkg::*;
#(
  parameter int  NUM_LANES = 2,
  parameter int  WORD_W    = 8,
  parameter int  TAP_MAX   = 15,
  parameter int  SETTLE    = 4,
  parameter int  MATCH_N   = 4,
  localparam int TAP_W     = $clog2(TAP_MAX + 1),
  localparam int LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        mode_fixed_i,
  input  logic [TAP_W-1:0]            fixed_steps_i,
  input  logic [WORD_W-1:0]           pattern_i,
  input  logic [NUM_LANES*WORD_W-1:0] rx_words_i,
  output logic [NUM_LANES-1:0]        dly_rst_o,
  output logic [NUM_LANES-1:0]        dly_ce_o,
  output logic [NUM_LANES-1:0]        dly_inc_o,
  output logic                        done_o,
  output logic [NUM_LANES-1:0]        cal_fail_o
);
  cal_state_e           state_q;
  logic [LANE_W-1:0]    lane_q;
  logic [TAP_W-1:0]     tap_q, seek_q, win_mid;
  logic [NUM_LANES-1:0] fail_q;
  logic                 rst_req, step_req, judge_go, judge_done, judge_pass;
  logic                 win_clr, win_upd, win_found;
  logic [WORD_W-1:0]    cur_word;

  assign cur_word   = rx_words_i[lane_q*WORD_W +: WORD_W];
  assign done_o     = (state_q == ST_DONE) && (fail_q == '0);
  assign cal_fail_o = (state_q == ST_DONE) ? fail_q : '0;

  always_comb begin
    rst_req  = 1'b0;
    step_req = 1'b0;
    judge_go = 1'b0;
    win_clr  = 1'b0;
    win_upd  = 1'b0;
    case (state_q)
      ST_LANE_RST: begin
        rst_req  = 1'b1;
        win_clr  = 1'b1;
        judge_go = !mode_fixed_i;
      end
      ST_JUDGE:      win_upd = judge_done;
      ST_SWEEP_STEP: begin
        step_req = 1'b1;
        judge_go = 1'b1;
      end
      ST_RECENTER:   rst_req = 1'b1;
      ST_SEEK:       step_req = (tap_q != seek_q);
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lane_q  <= '0;
      tap_q   <= '0;
      seek_q  <= '0;
      fail_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          state_q <= ST_LANE_RST;
          lane_q  <= '0;
          fail_q  <= '0;
        end
        ST_LANE_RST: begin
          tap_q <= '0;
          if (mode_fixed_i) begin
            seek_q  <= (fixed_steps_i > TAP_W'(TAP_MAX)) ? TAP_W'(TAP_MAX) : fixed_steps_i;
            state_q <= ST_SEEK;
          end else begin
            state_q <= ST_JUDGE;
          end
        end
        ST_JUDGE: if (judge_done) begin
          state_q <= (tap_q == TAP_W'(TAP_MAX)) ? ST_RECENTER : ST_SWEEP_STEP;
        end
        ST_SWEEP_STEP: begin
          tap_q   <= tap_q + 1'b1;
          state_q <= ST_JUDGE;
        end
        ST_RECENTER: begin
          // back to zero, then climb: no down-step ever needed
          tap_q   <= '0;
          seek_q  <= win_found ? win_mid : '0;
          if (!win_found) fail_q[lane_q] <= 1'b1;
          state_q <= ST_SEEK;
        end
        ST_SEEK: begin
          if (tap_q == seek_q) state_q <= ST_NEXT;
          else                 tap_q   <= tap_q + 1'b1;
        end
        ST_NEXT: begin
          if (lane_q == LANE_W'(NUM_LANES - 1)) begin
            state_q <= ST_DONE;
          end else begin
            lane_q  <= lane_q + 1'b1;
            state_q <= ST_LANE_RST;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  eye_cal_tap_judge #(
    .WORD_W (WORD_W),
    .SETTLE (SETTLE),
    .MATCH_N(MATCH_N)
  ) u_judge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (judge_go),
    .word_i   (cur_word),
    .pattern_i(pattern_i),
    .done_o   (judge_done),
    .pass_o   (judge_pass)
  );

  eye_cal_window #(
    .TAP_W(TAP_W)
  ) u_window (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (win_clr),
    .upd_i  (win_upd),
    .pass_i (judge_pass),
    .tap_i  (tap_q),
    .found_o(win_found),
    .mid_o  (win_mid)
  );

  eye_cal_dly_drive #(
    .NUM_LANES(NUM_LANES),
    .LANE_W   (LANE_W)
  ) u_drive (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lane_i    (lane_q),
    .rst_req_i (rst_req),
    .step_req_i(step_req),
    .dly_rst_o (dly_rst_o),
    .dly_ce_o  (dly_ce_o),
    .dly_inc_o (dly_inc_o)
  );
endmodule

// File: rtl/eye_cal_seq_chk.sv
module eye_cal_seq_chk #(
  parameter int NUM_LANES = 2,
  parameter int TAP_MAX   = 15,
  parameter int TAP_W     = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic [NUM_LANES-1:0] dly_rst_o,
  input logic [NUM_LANES-1:0] dly_ce_o,
  input logic [NUM_LANES-1:0] dly_inc_o,
  input logic                 done_o,
  input logic [NUM_LANES-1:0] cal_fail_o,
  input logic [TAP_W-1:0]     tap_i
);
  assert_one_lane_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dly_ce_o | dly_rst_o));

  assert_step_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dly_ce_o & ~dly_inc_o) == '0) && ((dly_ce_o & dly_rst_o) == '0));

  assert_tap_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tap_i) <= TAP_MAX);

  assert_done_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cal_fail_o == '0) && (dly_ce_o == '0) && (dly_rst_o == '0));

  assert_done_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  assert_fail_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_fail_o != '0) && !start_i |=> $stable(cal_fail_o) && (dly_ce_o == '0));
endmodule

bind eye_cal_seq eye_cal_seq_chk #(
  .NUM_LANES(NUM_LANES),
  .TAP_MAX  (TAP_MAX),
  .TAP_W    (TAP_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .dly_rst_o (dly_rst_o),
  .dly_ce_o  (dly_ce_o),
  .dly_inc_o (dly_inc_o),
  .done_o    (done_o),
  .cal_fail_o(cal_fail_o),
  .tap_i     (tap_q)
);

// File: tb/eye_cal_seq_test.sv
`timescale 1ns/1ps
module eye_cal_seq_test;
  localparam int NL = 3, W = 8, TMAX = 15, TW = 4;

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode_fixed = 1'b0, trk_clr = 1'b0;
  logic [TW-1:0] fixed_steps = '0;
  logic [W-1:0]  pattern = 8'hA5;
  logic [NL*W-1:0] rx_words;
  logic [NL-1:0] dly_rst, dly_ce, dly_inc, cal_fail;
  logic          done;

  int n_chk = 0, n_bad = 0;
  logic [TMAX:0] pass_map [NL];
  logic [TMAX:0] flaky_map[NL];
  int tap_m[NL], tap_hi[NL];
  int cyc, hi_lane;
  logic order_bad, dec_seen;

  always #2.5 clk = ~clk;

  eye_cal_seq #(.NUM_LANES(NL), .WORD_W(W), .TAP_MAX(TMAX), .SETTLE(4), .MATCH_N(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_fixed_i(mode_fixed),
    .fixed_steps_i(fixed_steps), .pattern_i(pattern), .rx_words_i(rx_words),
    .dly_rst_o(dly_rst), .dly_ce_o(dly_ce), .dly_inc_o(dly_inc),
    .done_o(done), .cal_fail_o(cal_fail));

  // delay-line model driven only by the output pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 0; hi_lane <= 0; order_bad <= 1'b0; dec_seen <= 1'b0;
      for (int l = 0; l < NL; l++) begin tap_m[l] <= 0; tap_hi[l] <= 0; end
    end else begin
      cyc <= cyc + 1;
      if (trk_clr) begin
        hi_lane <= 0; order_bad <= 1'b0; dec_seen <= 1'b0;
        for (int l = 0; l < NL; l++) tap_hi[l] <= 0;
      end else begin
        for (int l = 0; l < NL; l++) begin
          if (tap_m[l] > tap_hi[l]) tap_hi[l] <= tap_m[l];
          if (dly_rst[l] || dly_ce[l]) begin
            if (l < hi_lane) order_bad <= 1'b1;
            if (l > hi_lane) hi_lane <= l;
          end
        end
      end
      for (int l = 0; l < NL; l++) begin
        if (dly_rst[l]) tap_m[l] <= 0;
        else if (dly_ce[l]) begin
          if (dly_inc[l]) tap_m[l] <= tap_m[l] + 1;
          else begin tap_m[l] <= tap_m[l] - 1; dec_seen <= 1'b1; end
        end
      end
    end
  end

  always_comb begin
    for (int l = 0; l < NL; l++) begin
      logic good;
      good = 1'b0;
      if (tap_m[l] >= 0 && tap_m[l] <= TMAX)
        good = pass_map[l][tap_m[l]] && !(flaky_map[l][tap_m[l]] && (cyc % 4 == 0));
      rx_words[l*W +: W] = good ? pattern : (pattern ^ 8'h3C);
    end
  end

  function automatic logic [TMAX:0] span(int lo, int hi);
    logic [TMAX:0] m = '0;
    for (int t = lo; t <= hi; t++) m[t] = 1'b1;
    return m;
  endfunction

  // expected final tap from R4/R5/R6; -1 means no clean tap
  function automatic int exp_tap(logic [TMAX:0] p, logic [TMAX:0] f);
    logic [TMAX:0] eff = p & ~f;
    int run = 0, rlo = 0, blen = 0, blo = 0, bhi = 0;
    for (int t = 0; t <= TMAX; t++) begin
      if (eff[t]) begin
        if (run == 0) rlo = t;
        run++;
        if (run > blen) begin blen = run; blo = rlo; bhi = t; end
      end else run = 0;
    end
    return (blen == 0) ? -1 : (blo + bhi) / 2;
  endfunction

  task automatic check_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_cal(string tag, bit fixed, int steps);
    int w = 0;
    int e;
    bit all_ok = 1'b1;
    int snap[NL];
    @(negedge clk); trk_clr = 1'b1; mode_fixed = fixed; fixed_steps = TW'(steps);
    @(negedge clk); trk_clr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!(done || cal_fail != '0) && w < 20000) begin @(negedge clk); w++; end
    check_eq("R8", {tag, " finished in time"}, int'(w < 20000), 1);
    for (int l = 0; l < NL; l++) begin
      e = fixed ? ((steps > TMAX) ? TMAX : steps) : exp_tap(pass_map[l], flaky_map[l]);
      if (e < 0) all_ok = 1'b0;
      check_eq("R6", $sformatf("%s lane %0d final tap", tag, l), tap_m[l], (e < 0) ? 0 : e);
      check_eq("R7", $sformatf("%s lane %0d fail bit", tag, l), int'(cal_fail[l]), int'(e < 0));
      check_eq("R3", $sformatf("%s lane %0d max tap in range", tag, l), int'(tap_hi[l] <= TMAX), 1);
      snap[l] = tap_m[l];
    end
    check_eq("R3", {tag, " no down-step"}, int'(dec_seen), 0);
    check_eq("R2", {tag, " lane order"}, int'(order_bad), 0);
    check_eq("R8", {tag, " done flag"}, int'(done), int'(all_ok));
    repeat (30) @(negedge clk);
    for (int l = 0; l < NL; l++)
      check_eq("R8", $sformatf("%s lane %0d held", tag, l), tap_m[l], snap[l]);
    check_eq("R8", {tag, " done held"}, int'(done), int'(all_ok));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int l = 0; l < NL; l++) begin pass_map[l] = '0; flaky_map[l] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check_eq("R1", "done in reset", int'(done), 0);
    check_eq("R1", "pulses in reset", int'({dly_rst, dly_ce}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_eq("R1", "idle done", int'(done), 0);
    check_eq("R1", "idle fail", int'(cal_fail), 0);
    check_eq("R1", "idle pulses", int'({dly_rst, dly_ce}), 0);

    // R5: longest of two runs, window at low edge
    pass_map[0] = span(3, 9);
    pass_map[1] = span(2, 4) | span(8, 13);
    pass_map[2] = span(0, 4);
    run_cal("R5 longest", 1'b0, 0);

    // R5 tie: first run wins; window at high edge; single tap
    pass_map[0] = span(1, 3) | span(10, 12);
    pass_map[1] = span(12, 15);
    pass_map[2] = span(7, 7);
    run_cal("R5 tie", 1'b0, 0);

    // R7: empty lane between good lanes; full range
    pass_map[0] = span(0, 15);
    pass_map[1] = '0;
    pass_map[2] = span(5, 8);
    run_cal("R7 empty lane", 1'b0, 0);

    // R4: a single bad word fails the tap
    pass_map[0] = span(2, 10);  flaky_map[0] = span(6, 6);
    pass_map[1] = span(0, 15);  flaky_map[1] = span(0, 15);
    pass_map[2] = span(4, 12);  flaky_map[2] = span(4, 4);
    run_cal("R4 flaky", 1'b0, 0);
    for (int l = 0; l < NL; l++) flaky_map[l] = '0;

    // R9 fixed mode, maps empty so a sweep would fail
    for (int l = 0; l < NL; l++) pass_map[l] = '0;
    run_cal("R9 fixed 5", 1'b1, 5);
    run_cal("R9 fixed 0", 1'b1, 0);
    run_cal("R9 fixed 15", 1'b1, 15);

    // R10 restart after finish, no reset in between
    pass_map[0] = span(3, 9);
    pass_map[1] = span(6, 11);
    pass_map[2] = span(9, 14);
    run_cal("R10 restart", 1'b0, 0);

    // random maps
    for (int i = 0; i < 12; i++) begin
      pattern = 8'($urandom);
      for (int l = 0; l < NL; l++) begin
        int lo = $urandom % 16;
        int hi = lo + ($urandom % (16 - lo));
        pass_map[l]  = ($urandom % 8 == 0) ? '0 : (span(lo, hi) | (16'($urandom) & 16'($urandom)));
        flaky_map[l] = 16'($urandom) & 16'($urandom) & 16'($urandom);
      end
      run_cal("R5 random", 1'b0, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule